// File: doc/BRIEF.md
# Interrupt Enable Gate for a Small Accumulator Processor

This block keeps the interrupt-enable state of a small accumulator processor and decides, at each instruction boundary, whether the processor must leave its program and start its interrupt entry sequence. The processor reports every finished instruction with a one-cycle strobe and presents the 12-bit opcode of that instruction in the same cycle. Three I/O-transfer opcodes act on the enable state. Every other opcode only advances the boundary logic.

Interrupt requests come from three sources. The first is an internal periodic tick that counts completed instructions, so that it fires at the same point on every run. The second is a level from the printer side saying that output is ready. The third is a level from the keyboard side saying that input is ready. The block reports three things. It flags when the next instruction must be skipped. It pulses when an interrupt is taken. It shows the current enable state. The save-and-jump sequence itself belongs to the processor.

Top module: `irq_gate`

## Requirements
- R1: While rst_n is low at a clock edge, the enable flag, the pending delayed enable, the tick counter and the tick request are all cleared, and skip and take are low afterwards.
- R2: Opcode octal 6000 (skip-and-disable) completing while the enable flag is high raises skip for one cycle, in the cycle after the strobe. When the enable flag is low, skip stays low. In both cases the enable flag is low from the cycle after the strobe.
- R3: Opcode octal 6001 (delayed enable) does not raise the enable flag at its own boundary. The flag rises after the next completed instruction, and an interrupt may be taken at that next boundary.
- R4: Opcode octal 6002 (immediate disable) clears the enable flag from the cycle after its strobe and cancels a pending delayed enable. A 6001 followed by 6002 never makes the flag high.
- R5: take is a one-cycle pulse, in the cycle after an instruction strobe. It is raised only when the enable is effective (flag high, or a delayed enable maturing at this boundary) and at least one request is active.
- R6: Taking an interrupt clears the enable flag and any pending delayed enable at the same edge that raises take.
- R7: With the default period of 1000, the tick request sets at the boundary of the 1000th completed instruction. It stays set until tick_clr is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R8: Device requests are sampled only at instruction strobes and are not latched. A request level that goes away before the next strobe causes no interrupt.
- R9: An instruction with opcode 6000 or 6002 suppresses any interrupt at its own boundary, even when requests are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_done | input | 1 | One-cycle strobe: an instruction has completed |
| op_code | input | 12 | Opcode of the completing instruction, valid with instr_done |
| tto_rdy | input | 1 | Printer output-ready request level |
| tti_rdy | input | 1 | Keyboard input-ready request level |
| tick_clr | input | 1 | Clears the instruction-count tick request |
| skip | output | 1 | Skip the next instruction (one cycle after the strobe) |
| take | output | 1 | Interrupt taken (one-cycle pulse after the strobe) |
| ien | output | 1 | Current interrupt-enable flag |

## Verification
The embedded properties assume that instr_done is high for only one cycle at a time and that op_code is meaningful only while it is high. They also assume tick_clr is an occasional pulse and not a constant level. The stimulus drives every instruction as an isolated one-cycle strobe followed by an idle cycle, and it raises tick_clr only between instructions. Device levels change only on the falling clock edge. One idle cycle carries a request with no strobe, to show that the request is not latched.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Holds the opcode width, the three interrupt-control opcode values and the
// decoded opcode class shared by the decoder and the enable state machine.
// Assumes 12-bit instruction words with octal opcode values.
package irq_pkg;
    localparam int OP_W = 12;

    localparam logic [OP_W-1:0] OP_SKDIS = 12'o6000;
    localparam logic [OP_W-1:0] OP_ENDLY = 12'o6001;
    localparam logic [OP_W-1:0] OP_DISNOW = 12'o6002;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_SKDIS = 2'd1,
        CLS_ENDLY = 2'd2,
        CLS_DIS   = 2'd3
    } op_cls_t;
endpackage

// File: rtl/irq_op_decode.sv
// Module irq_op_decode
// Maps a completed instruction's opcode onto the interrupt-control class.
// Purely combinational. Assumes the opcode is meaningful only with the strobe.
module irq_op_decode
    import irq_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output op_cls_t         op_cls
);
    // Classify the opcode against the three control values
    always_comb begin
        unique case (op_code)
            OP_SKDIS:  op_cls = CLS_SKDIS;
            OP_ENDLY:  op_cls = CLS_ENDLY;
            OP_DISNOW: op_cls = CLS_DIS;
            default:   op_cls = CLS_OTHER;
        endcase
    end
endmodule

// File: rtl/irq_tick_gen.sv
// Module irq_tick_gen
// Counts completed instructions and raises a sticky tick request once every
// PERIOD completions. The request holds until a clear arrives; a set on the
// same edge as a clear wins. Assumes instr_done is a one-cycle strobe.
module irq_tick_gen #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic tick_clr,
    output logic tick_req
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Detect the completion that closes a period
    always_comb wrap = instr_done && (cnt_q == CNT_LAST);

    // Advance the instruction counter, wrapping at the period
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (wrap)       cnt_q <= '0;
        else if (instr_done) cnt_q <= cnt_q + 1'b1;
    end

    // Hold the tick request until cleared; a new tick beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        tick_req <= 1'b0;
        else if (wrap)     tick_req <= 1'b1;
        else if (tick_clr) tick_req <= 1'b0;
    end

    // R7
    cnt_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R7
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_req && !tick_clr) |=> tick_req);
endmodule

// File: rtl/irq_enable_fsm.sv
// Module irq_enable_fsm
// Keeps the enable flag and the pending delayed enable. At each instruction
// strobe it decides the skip and take outcomes, which are registered. Disables
// act at once. An enable matures at the next completed instruction. A take
// clears both bits. Assumes instr_done is a one-cycle strobe.
module irq_enable_fsm
    import irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    instr_done,
    input  op_cls_t op_cls,
    input  logic    any_req,
    output logic    ien_q,
    output logic    skip_q,
    output logic    take_q
);
    logic pend_q;
    logic dis_op;
    logic en_eff;
    logic take_d;
    logic skip_d;

    // Work out this boundary's disable, effective enable, take and skip
    always_comb begin
        dis_op = instr_done && (op_cls == CLS_SKDIS || op_cls == CLS_DIS);
        en_eff = ien_q || pend_q;
        take_d = instr_done && !dis_op && en_eff && any_req;
        skip_d = instr_done && (op_cls == CLS_SKDIS) && ien_q;
    end

    // Register the skip and take pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
            take_q <= 1'b0;
        end else begin
            skip_q <= skip_d;
            take_q <= take_d;
        end
    end

    // Update the enable flag and pending enable at instruction boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (instr_done) begin
            if (dis_op || take_d) begin
                ien_q  <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                if (pend_q) ien_q <= 1'b1;
                pend_q <= (op_cls == CLS_ENDLY);
            end
        end
    end

    // R2
    skip_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_q |-> !ien_q);

    // R4
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && op_cls == CLS_DIS) |=> (!ien_q && !pend_q));

    // R3
    late_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ien_q) |-> $past(pend_q && instr_done));

    // R6
    take_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> (!ien_q && !pend_q));

    // R5
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |=> !take_q);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |=> (!take_q && $stable(ien_q)));
endmodule

// File: rtl/irq_gate.sv
// Module irq_gate
// Top of the interrupt enable gate. It decodes the completing opcode, merges
// the instruction-count tick with the two device request levels, and drives
// the enable state machine. Assumes device levels are already synchronous to clk.
module irq_gate
    import irq_pkg::*;
#(
    parameter int TICK_PERIOD = 1000,
    parameter int N_SRC       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_done,
    input  logic [OP_W-1:0] op_code,
    input  logic            tto_rdy,
    input  logic            tti_rdy,
    input  logic            tick_clr,
    output logic            skip,
    output logic            take,
    output logic            ien
);
    op_cls_t          op_cls;
    logic             tick_req;
    logic [N_SRC-1:0] req_vec;
    logic [N_SRC:0]   req_or;
    logic             any_req;

    irq_op_decode u_dec (
        .op_code (op_code),
        .op_cls  (op_cls)
    );

    irq_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .tick_clr   (tick_clr),
        .tick_req   (tick_req)
    );

    // Gather the request sources into one vector
    always_comb req_vec = {tti_rdy, tto_rdy, tick_req};

    // Reduce the request sources one stage at a time
    assign req_or[0] = 1'b0;
    for (genvar i = 0; i < N_SRC; i++) begin : g_req
        assign req_or[i+1] = req_or[i] | req_vec[i];
    end
    assign any_req = req_or[N_SRC];

    irq_enable_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .op_cls     (op_cls),
        .any_req    (any_req),
        .ien_q      (ien),
        .skip_q     (skip),
        .take_q     (take)
    );
endmodule

// File: tb/sim_irq_gate.sv
`timescale 1ns/1ps
module sim_irq_gate;
    typedef struct {
        int    due;
        bit    e_skip;
        bit    e_take;
        bit    e_ien;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 1'b0;
    logic [11:0] op_code = 12'o7000;
    logic        tto_rdy = 1'b0;
    logic        tti_rdy = 1'b0;
    logic        tick_clr = 1'b0;
    logic        skip;
    logic        take;
    logic        ien;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    localparam logic [11:0] NOP = 12'o7000;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_gate u0 (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .op_code(op_code),
        .tto_rdy(tto_rdy), .tti_rdy(tti_rdy), .tick_clr(tick_clr),
        .skip(skip), .take(take), .ien(ien)
    );

    task automatic cmp(string tag, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Driver: one instruction strobe, expected outputs queued for the next cycle
    task automatic instr(logic [11:0] op, bit tto, bit tti,
                         bit e_skip, bit e_take, bit e_ien, string tag);
        @(negedge clk);
        instr_done = 1'b1;
        op_code    = op;
        tto_rdy    = tto;
        tti_rdy    = tti;
        sb.push_back('{cyc + 1, e_skip, e_take, e_ien, tag});
        @(negedge clk);
        instr_done = 1'b0;
        op_code    = NOP;
        tto_rdy    = 1'b0;
        tti_rdy    = 1'b0;
    endtask

    // Driver: a cycle without a strobe, with given request levels
    task automatic idle(bit tto, bit tti, bit e_ien, string tag);
        @(negedge clk);
        tto_rdy = tto;
        tti_rdy = tti;
        sb.push_back('{cyc + 1, 1'b0, 1'b0, e_ien, tag});
        @(negedge clk);
        tto_rdy = 1'b0;
        tti_rdy = 1'b0;
    endtask

    // Monitor: pop and compare when an expected item falls due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t it;
            it = sb.pop_front();
            cmp(it.tag, "skip", skip, it.e_skip);
            cmp(it.tag, "take", take, it.e_take);
            cmp(it.tag, "ien",  ien,  it.e_ien);
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "ien",  ien,  1'b0);
        cmp("R1", "take", take, 1'b0);
        cmp("R1", "skip", skip, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // R3: delayed enable, no request
        instr(12'o6001, 0, 0, 0, 0, 0, "R3 enable not yet");
        instr(NOP,      0, 0, 0, 0, 1, "R3 enable after next");
        // R7: strobes 3..1000 with no request, tick not yet set (also R1 counter cleared)
        for (int k = 3; k <= 1000; k++) instr(NOP, 0, 0, 0, 0, 1, "R7 before tick");
        instr(NOP, 0, 0, 0, 1, 0, "R7 tick take");
        // R7 sticky tick, R3 take at the maturing boundary
        instr(12'o6001, 0, 0, 0, 0, 0, "R3 pend with tick");
        instr(NOP,      0, 0, 0, 1, 0, "R7 R3 sticky tick take");
        @(negedge clk) tick_clr = 1'b1;
        @(negedge clk) tick_clr = 1'b0;
        instr(12'o6001, 0, 0, 0, 0, 0, "R7 after clr");
        instr(NOP,      0, 0, 0, 0, 1, "R7 cleared no take");
        instr(NOP,      0, 0, 0, 0, 1, "R7 cleared stays");

        // R2 skip and disable
        instr(12'o6000, 0, 0, 1, 0, 0, "R2 skip when enabled");
        instr(12'o6000, 0, 0, 0, 0, 0, "R2 no skip when disabled");

        // R4 cancel pending
        instr(12'o6001, 0, 0, 0, 0, 0, "R4 pend");
        instr(12'o6002, 0, 0, 0, 0, 0, "R4 disable");
        instr(NOP,      0, 0, 0, 0, 0, "R4 stays off");
        instr(NOP,      0, 0, 0, 0, 0, "R4 stays off 2");

        // R9 disabling opcodes suppress take
        instr(12'o6001, 0, 0, 0, 0, 0, "R9 pend");
        instr(NOP,      0, 0, 0, 0, 1, "R9 enabled");
        instr(12'o6000, 0, 1, 1, 0, 0, "R9 skdis with request");
        instr(12'o6001, 0, 0, 0, 0, 0, "R9 pend 2");
        instr(NOP,      0, 0, 0, 0, 1, "R9 enabled 2");
        instr(12'o6002, 1, 0, 0, 0, 0, "R9 dis with request");

        // R8 request without strobe is not latched; R5 take pulse
        instr(12'o6001, 0, 0, 0, 0, 0, "R8 pend");
        instr(NOP,      0, 0, 0, 0, 1, "R8 enabled");
        idle(1, 0, 1, "R8 idle request");
        instr(NOP,      0, 0, 0, 0, 1, "R8 no latched request");
        instr(NOP,      0, 1, 0, 1, 0, "R5 R6 take on keyboard");
        instr(NOP,      0, 1, 0, 0, 0, "R5 no take when disabled");

        // R6 take clears pending from a 6001 at the same boundary
        instr(12'o6001, 0, 0, 0, 0, 0, "R6 pend");
        instr(NOP,      0, 0, 0, 0, 1, "R6 enabled");
        instr(12'o6001, 1, 0, 0, 1, 0, "R6 take on 6001");
        instr(NOP,      0, 0, 0, 0, 0, "R6 pending cleared");

        // R3 6001 with request: no take at own boundary, take at next
        instr(12'o6001, 1, 0, 0, 0, 0, "R3 no take at own boundary");
        instr(NOP,      1, 0, 0, 1, 0, "R3 take at next boundary");

        repeat (3) @(negedge clk);
        cmp("R5", "queue drained", sb.size() == 0, 1'b1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule